// File: doc/BRIEF.md
# Pixel Output Depth Formatter

This block sits between the pixel pipeline of a display engine and the physical output interface. Each clock it may accept one 24-bit RGB pixel, marked by a valid strobe, and turn it into an output word for a narrower panel. A five-bit depth code chooses how many bits each colour channel keeps. Each channel keeps its most significant bits. The three shortened channels are packed next to each other, with either red or blue in the most significant field. The packed group is then placed at the top or at the bottom of the 24-bit output bus, and every bit outside the group is zero.

The datapath has a single register stage. Data-enable, horizontal sync and vertical sync pass through their own registers, so they stay aligned with the pixel they came with. The configuration inputs are sampled in the same cycle as the pixel. Software can therefore change the format between two pixels without a gap.

Top module: `pixel_depth_fmt`

## Requirements
- R1: The depth code selects the red/green/blue field widths as follows: 3→1/1/1, 6→2/2/2, 8→3/3/2, 9→3/3/3, 12→4/4/4, 15→5/5/5, 16→5/6/5, 18→6/6/6, 24→8/8/8. Each field holds the most significant bits of its 8-bit input channel.
- R2: Any depth code not listed in R1 gives the 8/8/8 format.
- R3: With `cfg_bgr_order`=0 the fields are packed red (most significant), then green, then blue. With `cfg_bgr_order`=1 they are packed blue (most significant), then green, then red.
- R4: With `cfg_msb_align`=0 the packed group starts at bit 0 of `out_pix`, and every bit above the group is zero.
- R5: With `cfg_msb_align`=1 the packed group ends at bit 23 of `out_pix`, and every bit below the group is zero.
- R6: A pixel presented with `in_valid`=1 at a rising edge appears on `out_pix` after that edge. `out_valid` equals `in_valid` delayed by exactly one clock.
- R7: `out_de`, `out_hs` and `out_vs` equal `in_de`, `in_hs` and `in_vs` delayed by exactly one clock.
- R8: When `in_valid` is 0, `out_pix` keeps its previous value, whatever the pixel and configuration inputs carry.
- R9: While `rst_n` is low (asynchronous, active low), every output is zero.
- R10: The configuration inputs take effect for the pixel sampled in the same cycle, so back-to-back pixels may each use a different format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 5 | Depth code (3,6,8,9,12,15,16,18,24) |
| cfg_msb_align | input | 1 | 1: group placed at the top of the bus, 0: at bit 0 |
| cfg_bgr_order | input | 1 | 1: blue is the most significant field, 0: red is |
| in_valid | input | 1 | Input pixel strobe |
| in_de | input | 1 | Data enable in |
| in_hs | input | 1 | Horizontal sync in |
| in_vs | input | 1 | Vertical sync in |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| out_valid | output | 1 | Output pixel strobe |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_pix | output | 24 | Formatted pixel word |

## Verification
The assertions check the following on every cycle:
- the one-clock delay of the strobe and of the three timing signals;
- that the pixel word holds while no pixel is accepted;
- that the bits above the group stay zero in bottom-aligned formats;
- that the full 8/8/8 red-first format passes the pixel through bit for bit.

The bench's vectors are the only check of the exact field placement in each of the nine formats. This includes the asymmetric 3/3/2 and 5/6/5 splits, both channel orders, top alignment and the fallback for unlisted codes. The bench also shows that the format can change between consecutive pixels and that a reset in the middle of a run clears the outputs.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

   // Width of a single field-width value (enough to hold 0..8)
   localparam int FW_W   = 4;
   // Width of the depth code
   localparam int CODE_W = 5;

   typedef struct packed {
      logic [FW_W-1:0] r_w;
      logic [FW_W-1:0] g_w;
      logic [FW_W-1:0] b_w;
   } ch_split_t;

   // Maps a depth code to per-channel widths; unknown codes fall back to 8/8/8
   function automatic ch_split_t split_of(input logic [CODE_W-1:0] code);
      ch_split_t s;
      case (code)
         5'd3:    s = '{r_w: 4'd1, g_w: 4'd1, b_w: 4'd1};
         5'd6:    s = '{r_w: 4'd2, g_w: 4'd2, b_w: 4'd2};
         5'd8:    s = '{r_w: 4'd3, g_w: 4'd3, b_w: 4'd2};
         5'd9:    s = '{r_w: 4'd3, g_w: 4'd3, b_w: 4'd3};
         5'd12:   s = '{r_w: 4'd4, g_w: 4'd4, b_w: 4'd4};
         5'd15:   s = '{r_w: 4'd5, g_w: 4'd5, b_w: 4'd5};
         5'd16:   s = '{r_w: 4'd5, g_w: 4'd6, b_w: 4'd5};
         5'd18:   s = '{r_w: 4'd6, g_w: 4'd6, b_w: 4'd6};
         default: s = '{r_w: 4'd8, g_w: 4'd8, b_w: 4'd8};
      endcase
      return s;
   endfunction

   // Sum of the three field widths
   function automatic logic [CODE_W-1:0] total_of(input ch_split_t s);
      return CODE_W'(s.r_w) + CODE_W'(s.g_w) + CODE_W'(s.b_w);
   endfunction

endpackage

// File: rtl/pdf_depth_decode.sv
module pdf_depth_decode
   import pdf_pkg::*;
#(
   parameter int CODE_BITS = 5
) (
   input  logic [CODE_BITS-1:0] code,
   output ch_split_t            split,
   output logic [CODE_BITS-1:0] total_w
);

   if (CODE_BITS != CODE_W) begin : g_bad_code
      $error("pdf_depth_decode: CODE_BITS must equal the package code width");
   end

   always_comb begin
      split   = split_of(code);
      total_w = total_of(split);
   end

endmodule

// File: rtl/pdf_chan_trunc.sv
module pdf_chan_trunc
   import pdf_pkg::*;
#(
   parameter int CH_W  = 8,
   parameter int OUT_W = 24
) (
   input  logic [CH_W-1:0]  chan,
   input  logic [FW_W-1:0]  keep_w,
   output logic [OUT_W-1:0] field
);

   localparam int PAD_W = OUT_W - CH_W;

   if (OUT_W < CH_W) begin : g_bad_w
      $error("pdf_chan_trunc: OUT_W smaller than CH_W");
   end

   logic [FW_W-1:0] drop;
   logic [CH_W-1:0] kept;

   always_comb begin
      drop  = FW_W'(CH_W) - keep_w;
      kept  = chan >> drop;
      field = {{PAD_W{1'b0}}, kept};
   end

endmodule

// File: rtl/pdf_packer.sv
module pdf_packer
   import pdf_pkg::*;
#(
   parameter int OUT_W = 24
) (
   input  logic [OUT_W-1:0]  f_hi,
   input  logic [OUT_W-1:0]  f_mid,
   input  logic [OUT_W-1:0]  f_lo,
   input  logic [FW_W-1:0]   w_mid,
   input  logic [FW_W-1:0]   w_lo,
   input  logic [CODE_W-1:0] total_w,
   input  logic              msb_align,
   output logic [OUT_W-1:0]  word
);

   localparam int SH_W = $clog2(OUT_W + 1);

   if (SH_W < CODE_W) begin : g_bad_sh
      $error("pdf_packer: OUT_W too small for the depth total");
   end

   logic [SH_W-1:0]  sh_hi;
   logic [SH_W-1:0]  sh_mid;
   logic [SH_W-1:0]  sh_top;
   logic [OUT_W-1:0] low_word;

   always_comb begin
      sh_mid   = SH_W'(w_lo);
      sh_hi    = SH_W'(w_mid) + SH_W'(w_lo);
      sh_top   = SH_W'(OUT_W) - SH_W'(total_w);
      low_word = (f_hi << sh_hi) | (f_mid << sh_mid) | f_lo;
      word     = msb_align ? (low_word << sh_top) : low_word;
   end

endmodule

// File: rtl/pixel_depth_fmt.sv
module pixel_depth_fmt
   import pdf_pkg::*;
#(
   parameter int CH_W      = 8,
   parameter int CODE_BITS = 5,
   parameter int N_CH      = 3,
   localparam int OUT_W    = N_CH * CH_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CODE_BITS-1:0] cfg_depth,
   input  logic                 cfg_msb_align,
   input  logic                 cfg_bgr_order,
   input  logic                 in_valid,
   input  logic                 in_de,
   input  logic                 in_hs,
   input  logic                 in_vs,
   input  logic [CH_W-1:0]      in_r,
   input  logic [CH_W-1:0]      in_g,
   input  logic [CH_W-1:0]      in_b,
   output logic                 out_valid,
   output logic                 out_de,
   output logic                 out_hs,
   output logic                 out_vs,
   output logic [OUT_W-1:0]     out_pix
);

   if (CH_W != 8) begin : g_bad_ch
      $error("pixel_depth_fmt: depth splits are defined for 8-bit channels");
   end
   if (N_CH != 3) begin : g_bad_n
      $error("pixel_depth_fmt: exactly three colour channels are supported");
   end

   localparam int IDX_R = 0;
   localparam int IDX_G = 1;
   localparam int IDX_B = 2;

   ch_split_t            split;
   logic [CODE_BITS-1:0] total_w;

   pdf_depth_decode #(.CODE_BITS(CODE_BITS)) u_dec (
      .code    (cfg_depth),
      .split   (split),
      .total_w (total_w)
   );

   logic [CH_W-1:0]  ch_in  [N_CH];
   logic [FW_W-1:0]  ch_w   [N_CH];
   logic [OUT_W-1:0] ch_fld [N_CH];

   always_comb begin
      ch_in[IDX_R] = in_r;
      ch_in[IDX_G] = in_g;
      ch_in[IDX_B] = in_b;
      ch_w[IDX_R]  = split.r_w;
      ch_w[IDX_G]  = split.g_w;
      ch_w[IDX_B]  = split.b_w;
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      pdf_chan_trunc #(.CH_W(CH_W), .OUT_W(OUT_W)) u_trunc (
         .chan   (ch_in[c]),
         .keep_w (ch_w[c]),
         .field  (ch_fld[c])
      );
   end

   // Channel order: the outer channels swap, green stays in the middle
   logic [OUT_W-1:0] f_hi, f_lo;
   logic [FW_W-1:0]  w_lo;

   always_comb begin
      if (cfg_bgr_order) begin
         f_hi = ch_fld[IDX_B];
         f_lo = ch_fld[IDX_R];
         w_lo = ch_w[IDX_R];
      end else begin
         f_hi = ch_fld[IDX_R];
         f_lo = ch_fld[IDX_B];
         w_lo = ch_w[IDX_B];
      end
   end

   logic [OUT_W-1:0] word_d;

   pdf_packer #(.OUT_W(OUT_W)) u_pack (
      .f_hi      (f_hi),
      .f_mid     (ch_fld[IDX_G]),
      .f_lo      (f_lo),
      .w_mid     (ch_w[IDX_G]),
      .w_lo      (w_lo),
      .total_w   (total_w),
      .msb_align (cfg_msb_align),
      .word      (word_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_de    <= 1'b0;
         out_hs    <= 1'b0;
         out_vs    <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= in_valid;
         out_de    <= in_de;
         out_hs    <= in_hs;
         out_vs    <= in_vs;
         if (in_valid) begin
            out_pix <= word_d;
         end
      end
   end

endmodule

// File: rtl/pdf_checker.sv
module pdf_checker
   import pdf_pkg::*;
#(
   parameter int CH_W      = 8,
   parameter int CODE_BITS = 5,
   localparam int OUT_W    = 3 * CH_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [CODE_BITS-1:0] cfg_depth,
   input logic                 cfg_msb_align,
   input logic                 cfg_bgr_order,
   input logic                 in_valid,
   input logic                 in_de,
   input logic                 in_hs,
   input logic                 in_vs,
   input logic [CH_W-1:0]      in_r,
   input logic [CH_W-1:0]      in_g,
   input logic [CH_W-1:0]      in_b,
   input logic                 out_valid,
   input logic                 out_de,
   input logic                 out_hs,
   input logic                 out_vs,
   input logic [OUT_W-1:0]     out_pix
);

   logic                 live;
   logic [CODE_BITS-1:0] depth_q;
   logic                 msb_q;
   logic                 bgr_q;
   logic [OUT_W-1:0]     raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live    <= 1'b0;
         depth_q <= '0;
         msb_q   <= 1'b0;
         bgr_q   <= 1'b0;
         raw_q   <= '0;
      end else begin
         live    <= 1'b1;
         depth_q <= cfg_depth;
         msb_q   <= cfg_msb_align;
         bgr_q   <= cfg_bgr_order;
         raw_q   <= {in_r, in_g, in_b};
      end
   end

   logic [CODE_BITS-1:0] used_w;
   always_comb used_w = total_of(split_of(depth_q));

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> out_valid == $past(in_valid)); // R6

   AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> {out_de, out_hs, out_vs} == $past({in_de, in_hs, in_vs})); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !$past(in_valid)) |-> $stable(out_pix)); // R8

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (live && out_valid && !msb_q) |-> ((out_pix >> used_w) == '0)); // R4

   AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (live && out_valid && depth_q == CODE_BITS'(24) && !bgr_q) |-> out_pix == raw_q); // R1

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert ({out_valid, out_de, out_hs, out_vs} == 4'b0 && out_pix == '0); // R9
      end
   end

endmodule

bind pixel_depth_fmt pdf_checker #(.CH_W(CH_W), .CODE_BITS(CODE_BITS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_depth     (cfg_depth),
   .cfg_msb_align (cfg_msb_align),
   .cfg_bgr_order (cfg_bgr_order),
   .in_valid      (in_valid),
   .in_de         (in_de),
   .in_hs         (in_hs),
   .in_vs         (in_vs),
   .in_r          (in_r),
   .in_g          (in_g),
   .in_b          (in_b),
   .out_valid     (out_valid),
   .out_de        (out_de),
   .out_hs        (out_hs),
   .out_vs        (out_vs),
   .out_pix       (out_pix)
);

// File: tb/pixel_depth_fmt_bench.sv
module pixel_depth_fmt_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cfg_depth = 5'd24;
   logic        cfg_msb_align = 1'b0;
   logic        cfg_bgr_order = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_de = 1'b0;
   logic        in_hs = 1'b0;
   logic        in_vs = 1'b0;
   logic [7:0]  in_r = '0, in_g = '0, in_b = '0;
   logic        out_valid, out_de, out_hs, out_vs;
   logic [23:0] out_pix;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pixel_depth_fmt u_pixel_depth_fmt (
      .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
      .cfg_msb_align(cfg_msb_align), .cfg_bgr_order(cfg_bgr_order),
      .in_valid(in_valid), .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
      .in_r(in_r), .in_g(in_g), .in_b(in_b),
      .out_valid(out_valid), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
      .out_pix(out_pix)
   );

   // {depth, msb_align, bgr_order, r, g, b, expected}
   localparam int NV = 20;
   localparam logic [54:0] VEC [NV] = '{
      {5'd24, 1'b0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'hA53CF0},
      {5'd24, 1'b0, 1'b1, 8'hA5, 8'h3C, 8'hF0, 24'hF03CA5},
      {5'd3,  1'b0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'h000005},
      {5'd3,  1'b1, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'hA00000},
      {5'd6,  1'b0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'h000023},
      {5'd8,  1'b0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'h0000A7},
      {5'd8,  1'b0, 1'b1, 8'hA5, 8'h3C, 8'hF0, 24'h0000CD},
      {5'd9,  1'b1, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'hA78000},
      {5'd12, 1'b0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'h000A3F},
      {5'd15, 1'b0, 1'b1, 8'hA5, 8'h3C, 8'hF0, 24'h0078F4},
      {5'd16, 1'b0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'h00A1FE},
      {5'd16, 1'b1, 1'b1, 8'hA5, 8'h3C, 8'hF0, 24'hF1F400},
      {5'd18, 1'b0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'h0293FC},
      {5'd18, 1'b1, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'hA4FF00},
      {5'd0,  1'b0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'hA53CF0},
      {5'd31, 1'b1, 1'b1, 8'hA5, 8'h3C, 8'hF0, 24'hF03CA5},
      {5'd24, 1'b1, 1'b0, 8'hA5, 8'h3C, 8'hF0, 24'hA53CF0},
      {5'd12, 1'b1, 1'b1, 8'hA5, 8'h3C, 8'hF0, 24'hF3A000},
      {5'd16, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 24'h00FFFF},
      {5'd6,  1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, 24'hFC0000}
   };

   task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic string vec_tag(input logic [4:0] d);
      case (d)
         5'd3, 5'd6, 5'd8, 5'd9, 5'd12, 5'd15, 5'd16, 5'd18, 5'd24:
            return "R1 R3 R4 R5 R10 format vector";
         default:
            return "R2 unlisted code falls back to 888";
      endcase
   endfunction

   task automatic drive_vec(input int i);
      cfg_depth     = VEC[i][54:50];
      cfg_msb_align = VEC[i][49];
      cfg_bgr_order = VEC[i][48];
      in_r          = VEC[i][47:40];
      in_g          = VEC[i][39:32];
      in_b          = VEC[i][31:24];
      in_valid      = 1'b1;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: outputs cleared while reset is held
      chk("R9 reset pix", out_pix, 24'h0);
      chk("R9 reset flags", {20'h0, out_valid, out_de, out_hs, out_vs}, 24'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: back-to-back pixels, format changes every cycle (R10)
      for (int i = 0; i < NV; i++) begin
         drive_vec(i);
         @(negedge clk);
         chk(vec_tag(VEC[i][54:50]), out_pix, VEC[i][23:0]);
      end

      // R6: valid strobe delayed one clock, then drops
      chk("R6 out_valid high", {23'h0, out_valid}, 24'h1);
      in_valid = 1'b0;
      // R8: new pixel and config while idle must not reach out_pix
      cfg_depth = 5'd3; cfg_msb_align = 1'b0; cfg_bgr_order = 1'b0;
      in_r = 8'h00; in_g = 8'h00; in_b = 8'h00;
      @(negedge clk);
      chk("R6 out_valid low", {23'h0, out_valid}, 24'h0);
      chk("R8 hold while idle", out_pix, 24'hFC0000);
      @(negedge clk);
      chk("R8 hold second idle cycle", out_pix, 24'hFC0000);

      // R7: timing signals delayed by exactly one clock
      in_de = 1'b1; in_hs = 1'b0; in_vs = 1'b1;
      #1;
      chk("R7 no early pass", {21'h0, out_de, out_hs, out_vs}, 24'h0);
      @(negedge clk);
      chk("R7 de/hs/vs pattern A", {21'h0, out_de, out_hs, out_vs}, 24'h5);
      in_de = 1'b0; in_hs = 1'b1; in_vs = 1'b0;
      @(negedge clk);
      chk("R7 de/hs/vs pattern B", {21'h0, out_de, out_hs, out_vs}, 24'h2);

      // R6: single pixel, 565 red first, top aligned: 5'b11111,6'b000000,5'b00000
      cfg_depth = 5'd16; cfg_msb_align = 1'b1; cfg_bgr_order = 1'b0;
      in_r = 8'hF8; in_g = 8'h03; in_b = 8'h07; in_valid = 1'b1;
      #1;
      chk("R6 no same-cycle output", out_pix, 24'hFC0000);
      @(negedge clk);
      chk("R6 R1 565 drops low bits", out_pix, 24'hF80000);
      in_valid = 1'b0;

      // R9: reset in the middle of a run clears everything
      in_de = 1'b1; in_hs = 1'b1; in_vs = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R9 mid-run reset pix", out_pix, 24'h0);
      chk("R9 mid-run reset flags", {20'h0, out_valid, out_de, out_hs, out_vs}, 24'h0);
      in_de = 1'b0; in_hs = 1'b0; in_vs = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule